// File: doc/BRIEF.md
# Serial Channel Configuration Port

This block is the write-only host port through which a two-channel speech codec engine receives its per-channel settings. A host frames each transaction with an active-low chip select and shifts bits in on a serial clock and data line. All three serial inputs are brought into the system clock domain by a short synchronizer. The block counts bits and collects them into a frame buffer. When chip select returns high, it decides from the bit count whether the frame was a control-only write or a full write that also carries time slots.

The first byte of every frame picks the target channel. The second byte carries that channel's control settings. In a full write, the third and fourth bytes carry the input and output time slots. A frame of any other length is dropped. A full write whose time-slot bytes have reserved bits set is also dropped and reported on a one-cycle flag. A write that sets the algorithm-reset bit in the control byte produces a single-cycle reset pulse toward the selected channel's datapath. That bit is never stored. The port only listens while the software-configuration input is high.

Top module: `chan_cfg_port`

## Requirements
- R1: After reset every control field reads zero: A-law, decode, no bypass, rate code 0, time slots 0, and no reset pulse or invalid flag.
- R2: A frame of exactly 16 bits loads the control fields of the channel named by bit 0 of the first byte (0 = X, 1 = Y). It leaves the time slots and the other channel unchanged. Bits 7:1 of the first byte are ignored.
- R3: Bits arrive least significant first within a byte and are sampled on the serial clock's rising edge. Bytes arrive in order. In the control byte, bit 1 is bypass, bit 2 is format (1 = mu-law), bits 4:3 are the rate code, bit 5 is coding (1 = encode), and bits 7:6 are ignored.
- R4: A frame of exactly 32 bits loads the control fields plus the input time slot (third byte, bits 5:0) and the output time slot (fourth byte, bits 5:0).
- R5: A 32-bit frame with bits 7:6 of the third or fourth byte nonzero changes no register and raises `cfg_invalid` for exactly one cycle.
- R6: A frame of any length other than 16 or 32 bits is discarded without any register change.
- R7: While `sw_cfg_en` is low, no frame changes any register or produces any pulse.
- R8: Bit 0 of the control byte, on an accepted write, produces exactly one single-cycle pulse on the selected channel's `alg_rst` bit. The bit is not stored, and at most one channel pulses at a time.
- R9: The level of the serial clock when chip select falls does not matter: no bit is counted until a rising edge occurs with chip select low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_cfg_en | input | 1 | High enables configuration through the serial port |
| cs_n | input | 1 | Active-low transaction frame from the host |
| sclk | input | 1 | Serial bit clock from the host |
| sdi | input | 1 | Serial data from the host |
| bypass | output | 2 | Per-channel bypass enable |
| mulaw | output | 2 | Per-channel format, 1 = mu-law, 0 = A-law |
| encode | output | 2 | Per-channel coding, 1 = compress, 0 = expand |
| rate_sel | output | 4 | Per-channel 2-bit rate code, channel 0 in bits 1:0 |
| in_slot | output | 12 | Per-channel 6-bit input time slot |
| out_slot | output | 12 | Per-channel 6-bit output time slot |
| alg_rst | output | 2 | Per-channel single-cycle algorithm reset pulse |
| cfg_invalid | output | 1 | Single-cycle pulse for a full write rejected by reserved bits |

## Verification
The bench sweeps every control byte value on one channel and a stride of values on the other. This catches any swapped or shifted field and any leakage of the ignored high bits. A design that used the wrong bit order or misplaced a field would miscompare on nearly every step. A design that stored the reset bit would pulse on the following write. The bench walks every input time slot with a matching output slot. It then sends full writes with each reserved pattern: a design that loaded them anyway would show changed slots, and one that forgot the flag would miss the pulse count. It sends frames of 8, 15, 17, 24, 31 and 33 bits, where a design that counted loosely or saturated wrongly would commit a register. It also sends frames with software mode off and a frame begun with the serial clock high, where a design that counted that initial level as an edge would shift every field by one bit.

// File: rtl/chan_cfg_pkg.sv
// Shared constants for the serial channel configuration port.
// Assumes the frame layout: byte 0 address, byte 1 control, bytes 2/3 slots.
package chan_cfg_pkg;
    localparam int FRAME_SHORT = 16;
    localparam int FRAME_LONG  = 32;
    localparam int BYTE_W      = 8;

    // Control byte bit positions (within byte 1)
    localparam int CB_ARST = 0;
    localparam int CB_BYP  = 1;
    localparam int CB_LAW  = 2;
    localparam int CB_RATE = 3;
    localparam int CB_ENC  = 5;

    typedef struct packed {
        logic       encode;
        logic [1:0] rate;
        logic       mulaw;
        logic       bypass;
    } chan_ctrl_t;
endpackage

// File: rtl/cfg_sync.sv
// Multi-bit, multi-stage synchronizer for slow host inputs.
// Assumes each input changes far slower than clk; bits are not coherent.
module cfg_sync #(
    parameter int            WIDTH  = 3,
    parameter int            STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    // Shift the inputs through STAGES flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cfg_frame_rx.sv
// Collects a serial frame, counts its bits and decides at chip-select rise
// whether it is a control write, a full write, an invalid full write or junk.
// Assumes synchronized inputs; sclk must be slower than clk/2.
module cfg_frame_rx
    import chan_cfg_pkg::*;
#(
    parameter int SLOT_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  cs_s,
    input  logic                  sclk_s,
    input  logic                  sdi_s,
    output logic [FRAME_LONG-1:0] frame,
    output logic                  load_ctrl,
    output logic                  load_slots,
    output logic                  bad
);
    localparam int CNT_W   = $clog2(FRAME_LONG + 2);
    localparam int CNT_SAT = FRAME_LONG + 1;
    localparam int RSV_W   = BYTE_W - SLOT_W;

    logic [CNT_W-1:0] cnt;
    logic             cs_q, sclk_q;
    logic             sclk_rise, cs_fall, cs_rise;
    logic             rsv_ok, is_short, is_long;

    assign sclk_rise = sclk_s && !sclk_q && !cs_s;
    assign cs_fall   = !cs_s && cs_q;
    assign cs_rise   = cs_s && !cs_q;
    assign rsv_ok    = (frame[2*BYTE_W+SLOT_W +: RSV_W] == '0) &&
                       (frame[3*BYTE_W+SLOT_W +: RSV_W] == '0);
    assign is_short  = (cnt == CNT_W'(FRAME_SHORT));
    assign is_long   = (cnt == CNT_W'(FRAME_LONG));

    // Edge history of chip select and serial clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            cs_q   <= cs_s;
            sclk_q <= sclk_s;
        end
    end

    // Bit counter (saturating past a long frame) and frame capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            frame <= '0;
        end else if (cs_fall) begin
            cnt <= '0;
        end else if (sclk_rise) begin
            if (cnt < CNT_W'(FRAME_LONG)) frame[cnt[$clog2(FRAME_LONG)-1:0]] <= sdi_s;
            if (cnt != CNT_W'(CNT_SAT)) cnt <= cnt + 1'b1;
        end
    end

    // Frame verdict at the end of the transaction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_ctrl  <= 1'b0;
            load_slots <= 1'b0;
            bad        <= 1'b0;
        end else begin
            load_ctrl  <= en && cs_rise && (is_short || (is_long && rsv_ok));
            load_slots <= en && cs_rise && is_long && rsv_ok;
            bad        <= en && cs_rise && is_long && !rsv_ok;
        end
    end
endmodule

// File: rtl/cfg_chan_regs.sv
// Per-channel storage of control fields and time slots, plus the
// self-clearing algorithm reset pulse. Assumes load strobes are one cycle.
module cfg_chan_regs
    import chan_cfg_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int SLOT_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [FRAME_LONG-1:0]    frame,
    input  logic                     load_ctrl,
    input  logic                     load_slots,
    output chan_ctrl_t [NUM_CH-1:0]  ctrl,
    output logic [NUM_CH*SLOT_W-1:0] in_slot,
    output logic [NUM_CH*SLOT_W-1:0] out_slot,
    output logic [NUM_CH-1:0]        alg_rst
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [CH_W-1:0]   sel;
    logic [BYTE_W-1:0] cbyte;
    chan_ctrl_t        cnew;

    assign sel   = frame[CH_W-1:0];
    assign cbyte = frame[BYTE_W +: BYTE_W];
    assign cnew  = '{encode: cbyte[CB_ENC], rate: cbyte[CB_RATE +: 2],
                     mulaw: cbyte[CB_LAW], bypass: cbyte[CB_BYP]};

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        assign hit = (sel == CH_W'(i));

        // Control fields and reset pulse for channel i
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctrl[i]    <= '0;
                alg_rst[i] <= 1'b0;
            end else begin
                alg_rst[i] <= load_ctrl && hit && cbyte[CB_ARST];
                if (load_ctrl && hit) ctrl[i] <= cnew;
            end
        end

        // Time slots for channel i
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                in_slot[i*SLOT_W +: SLOT_W]  <= '0;
                out_slot[i*SLOT_W +: SLOT_W] <= '0;
            end else if (load_slots && hit) begin
                in_slot[i*SLOT_W +: SLOT_W]  <= frame[2*BYTE_W +: SLOT_W];
                out_slot[i*SLOT_W +: SLOT_W] <= frame[3*BYTE_W +: SLOT_W];
            end
        end
    end
endmodule

// File: rtl/chan_cfg_port.sv
// Top of the serial channel configuration port: synchronizes the host
// inputs, frames the transaction and drives per-channel settings.
// Assumes sclk at most a quarter of clk and cs_n held high between frames.
module chan_cfg_port
    import chan_cfg_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int SLOT_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sw_cfg_en,
    input  logic                     cs_n,
    input  logic                     sclk,
    input  logic                     sdi,
    output logic [NUM_CH-1:0]        bypass,
    output logic [NUM_CH-1:0]        mulaw,
    output logic [NUM_CH-1:0]        encode,
    output logic [NUM_CH*2-1:0]      rate_sel,
    output logic [NUM_CH*SLOT_W-1:0] in_slot,
    output logic [NUM_CH*SLOT_W-1:0] out_slot,
    output logic [NUM_CH-1:0]        alg_rst,
    output logic                     cfg_invalid
);
    logic                    cs_s, sclk_s, sdi_s;
    logic [FRAME_LONG-1:0]   frame;
    logic                    load_ctrl, load_slots;
    chan_ctrl_t [NUM_CH-1:0] ctrl;

    cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({cs_n, sclk, sdi}), .q({cs_s, sclk_s, sdi_s})
    );

    cfg_frame_rx #(.SLOT_W(SLOT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(sw_cfg_en),
        .cs_s(cs_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
        .frame(frame), .load_ctrl(load_ctrl), .load_slots(load_slots),
        .bad(cfg_invalid)
    );

    cfg_chan_regs #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .frame(frame),
        .load_ctrl(load_ctrl), .load_slots(load_slots),
        .ctrl(ctrl), .in_slot(in_slot), .out_slot(out_slot),
        .alg_rst(alg_rst)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_out
        assign bypass[i]         = ctrl[i].bypass;
        assign mulaw[i]          = ctrl[i].mulaw;
        assign encode[i]         = ctrl[i].encode;
        assign rate_sel[2*i +: 2] = ctrl[i].rate;
    end
endmodule

// File: rtl/chan_cfg_port_checker.sv
// Properties on the configuration port's outputs, bound to the top module.
module chan_cfg_port_checker #(
    parameter int NUM_CH = 2,
    parameter int SLOT_W = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sw_cfg_en,
    input logic [NUM_CH-1:0]        bypass,
    input logic [NUM_CH-1:0]        mulaw,
    input logic [NUM_CH-1:0]        encode,
    input logic [NUM_CH*2-1:0]      rate_sel,
    input logic [NUM_CH*SLOT_W-1:0] in_slot,
    input logic [NUM_CH*SLOT_W-1:0] out_slot,
    input logic [NUM_CH-1:0]        alg_rst,
    input logic                     cfg_invalid
);
    // R1: one cycle after reset is sampled, all settings are zero
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (bypass == '0 && mulaw == '0 && encode == '0 &&
                    rate_sel == '0 && in_slot == '0 && out_slot == '0 &&
                    alg_rst == '0 && !cfg_invalid));

    // R5: a rejected full write leaves the time slots and controls alone
    a_r5_invalid_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_invalid |-> ($stable(in_slot) && $stable(out_slot) &&
                         $stable(rate_sel) && $stable(encode)));

    // R5: invalid flag is a single-cycle pulse
    a_r5_invalid_single: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_invalid |=> !cfg_invalid);

    // R7: with software mode off, nothing changes
    a_r7_disabled_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_cfg_en && $past(!sw_cfg_en)) |=>
            ($stable(bypass) && $stable(mulaw) && $stable(encode) &&
             $stable(rate_sel) && $stable(in_slot) && $stable(out_slot) &&
             alg_rst == '0));

    // R8: at most one channel pulses, and each pulse lasts one cycle
    a_r8_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alg_rst));

    a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        (alg_rst != '0) |=> (alg_rst == '0));

    // R8: reset pulse never coincides with a rejected write
    a_r8_no_pulse_on_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_invalid |-> (alg_rst == '0));
endmodule

bind chan_cfg_port chan_cfg_port_checker #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sw_cfg_en(sw_cfg_en),
    .bypass(bypass), .mulaw(mulaw), .encode(encode), .rate_sel(rate_sel),
    .in_slot(in_slot), .out_slot(out_slot), .alg_rst(alg_rst),
    .cfg_invalid(cfg_invalid)
);

// File: tb/chan_cfg_port_test.sv
// Self-checking bench: sweeps control bytes and time slots, probes frame
// lengths, reserved bits, disable and clock polarity at chip-select fall.
module chan_cfg_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_cfg_en = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic [1:0]  bypass, mulaw, encode, alg_rst;
    logic [3:0]  rate_sel;
    logic [11:0] in_slot, out_slot;
    logic        cfg_invalid;

    int checks = 0, failures = 0;
    int pulse_cnt [2];
    int bad_cnt = 0;
    int exp_pulse [2];
    int exp_bad = 0;
    logic [4:0] exp_ctrl [2];   // {encode, rate[1:0], mulaw, bypass}
    logic [5:0] exp_in [2], exp_out [2];

    chan_cfg_port uut (
        .clk(clk), .rst_n(rst_n), .sw_cfg_en(sw_cfg_en), .cs_n(cs_n),
        .sclk(sclk), .sdi(sdi), .bypass(bypass), .mulaw(mulaw),
        .encode(encode), .rate_sel(rate_sel), .in_slot(in_slot),
        .out_slot(out_slot), .alg_rst(alg_rst), .cfg_invalid(cfg_invalid)
    );

    always #5 clk = ~clk;

    // Observe single-cycle pulses
    always @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 2; i++) if (alg_rst[i]) pulse_cnt[i]++;
            if (cfg_invalid) bad_cnt++;
        end
    end

    initial begin
        #1_500_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Shift a frame: nbits LSB-first, optionally starting with sclk high
    task automatic xfer(input int nbits, input logic [39:0] d, input bit hi_start);
        @(negedge clk);
        sclk = hi_start;
        repeat (4) @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int b = 0; b < nbits; b++) begin
            sclk = 1'b0;
            sdi  = d[b];
            repeat (4) @(negedge clk);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
        end
        sclk = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    // Model of the expected effect of a frame
    task automatic model(input int nbits, input logic [39:0] d);
        int ch;
        ch = int'(d[0]);
        if (!sw_cfg_en) return;
        if (nbits == 32 && (d[23:22] != 0 || d[31:30] != 0)) begin
            exp_bad++;
            return;
        end
        if (nbits != 16 && nbits != 32) return;
        exp_ctrl[ch] = {d[13], d[12:11], d[10], d[9]};
        if (d[8]) exp_pulse[ch]++;
        if (nbits == 32) begin
            exp_in[ch]  = d[21:16];
            exp_out[ch] = d[29:24];
        end
    endtask

    task automatic check_all(input string req);
        logic [45:0] got, exp;
        got = {encode[1], rate_sel[3:2], mulaw[1], bypass[1],
               encode[0], rate_sel[1:0], mulaw[0], bypass[0],
               in_slot, out_slot};
        exp = {exp_ctrl[1], exp_ctrl[0], exp_in[1], exp_in[0], exp_out[1], exp_out[0]};
        checks++;
        if (got !== exp || pulse_cnt[0] != exp_pulse[0] ||
            pulse_cnt[1] != exp_pulse[1] || bad_cnt != exp_bad) begin
            failures++;
            $display("FAIL %s got=%h exp=%h pulses=%0d/%0d exp=%0d/%0d bad=%0d exp=%0d",
                     req, got, exp, pulse_cnt[0], pulse_cnt[1],
                     exp_pulse[0], exp_pulse[1], bad_cnt, exp_bad);
        end
    endtask

    task automatic run(input int nbits, input logic [39:0] d, input bit hi, input string req);
        xfer(nbits, d, hi);
        model(nbits, d);
        check_all(req);
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin
            exp_ctrl[i] = '0; exp_in[i] = '0; exp_out[i] = '0;
            exp_pulse[i] = 0; pulse_cnt[i] = 0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R1 reset state");

        // R2 R3 R8: every control byte on channel X, address high bits noisy
        for (int v = 0; v < 256; v++)
            run(16, {24'h0, 8'(v), 8'(v & 8'hFE)}, 1'b0, "R2/R3/R8 ctrl sweep X");
        // R2: stride over channel Y, channel X must hold its last value
        for (int v = 3; v < 256; v += 9)
            run(16, {24'h0, 8'(v), 8'hA5}, 1'b0, "R2 ctrl sweep Y");

        // R4: every input slot with a mirrored output slot, channels alternate
        for (int s = 0; s < 64; s++)
            run(32, {8'h0, 8'(63 - s), 8'(s), 8'(s * 5), 8'(s & 1)}, 1'b0, "R4 slot sweep");

        // R5: each nonzero reserved pattern in either slot byte
        for (int r = 1; r < 4; r++) begin
            run(32, {8'h0, 8'h15, {2'(r), 6'h2A}, 8'h3F, 8'h00}, 1'b0, "R5 reserved in-slot");
            run(32, {8'h0, {2'(r), 6'h11}, 8'h07, 8'h21, 8'h01}, 1'b0, "R5 reserved out-slot");
        end

        // R6: wrong frame lengths are discarded
        run(8,  40'h00_0000_0001, 1'b0, "R6 length 8");
        run(15, 40'h00_0000_3F01, 1'b0, "R6 length 15");
        run(17, 40'h00_0001_3F00, 1'b0, "R6 length 17");
        run(24, 40'h00_0012_3F01, 1'b0, "R6 length 24");
        run(31, 40'h00_1A2B_3F00, 1'b0, "R6 length 31");
        run(33, 40'h01_1A2B_3F01, 1'b0, "R6 length 33");

        // R7: software mode off
        sw_cfg_en = 1'b0;
        run(32, 40'h00_0C0D_3F00, 1'b0, "R7 disabled full write");
        run(16, 40'h00_0000_2B01, 1'b0, "R7 disabled ctrl write");
        sw_cfg_en = 1'b1;

        // R8: reset bit not stored -- pulse then no pulse
        run(16, 40'h00_0000_0F00, 1'b0, "R8 reset pulse set");
        run(16, 40'h00_0000_0E00, 1'b0, "R8 reset bit not retained");

        // R9: serial clock high at chip-select fall
        run(16, 40'h00_0000_3601, 1'b1, "R9 sclk high at start ctrl");
        run(32, 40'h00_2513_2901, 1'b1, "R9 sclk high at start full");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule